// File: doc/BRIEF.md
# Split Direct-Mapped Address Translation Buffer

This block caches page translations for a 32-bit virtual address space with 512-byte pages. It holds two separate direct-mapped buffers. One serves the system half of the address space, where virtual address bit 31 is set. The other serves the process half. Each entry stores a tag and a translation word. The translation word holds a physical frame number, a read-enable bit and a write-enable bit for each of four privilege modes, and a cached modified flag.

A lookup request carries a virtual address, a privilege mode, a write flag and a probe flag. The response is either a hit with the physical address or a miss, which asks the surrounding logic to walk the page tables and fill the entry. Lookups use a valid/ready stream on the request side and on the response side. A request is accepted on a clock edge where `lk_valid` and `lk_ready` are both high. Its response is registered and appears on the next cycle. `lk_ready` is high when no response is pending or when the pending response is being taken in the same cycle. A response stays on the bus unchanged until `rs_ready` takes it.

The control ports are plain signals:
- a fill port that writes one entry;
- an invalidate port with three operations;
- a debug port that reads and writes any entry of either buffer.

Top module: `tlb_split`

## Requirements
- R1: Virtual address bit 31 selects the buffer: 1 selects the system buffer and 0 selects the process buffer. An entry filled in one buffer is never seen by a lookup in the other buffer, even at the same index.
- R2: The page offset is `vaddr[8:0]`, the virtual page number (VPN) is `vaddr[31:9]`, and the buffer index is `vaddr[15:9]`. On a hit, `rs_paddr` is the entry's 21-bit frame number followed by the 9-bit page offset.
- R3: A lookup misses when the stored tag differs from `{1'b0, VPN}`, including the case of a different VPN that shares the same index.
- R4: The mode encoding is 0 kernel, 1 executive, 2 supervisor, 3 user. A read lookup needs read bit `rd[mode]` set and a write lookup needs write bit `wr[mode]` set; otherwise it misses.
- R5: A non-probe write lookup misses when the entry's modified flag is clear, even when the tag and permission match.
- R6: A probe lookup ignores the modified flag and checks only the tag and the permission bit.
- R7: Invalidate operation 1 (`inv_op`=1) invalidates every process entry and leaves the system entries intact.
- R8: Invalidate operation 2 invalidates every entry of both buffers.
- R9: Invalidate operation 3 invalidates only the entry at index `inv_vpn[6:0]` of the buffer selected by `inv_vpn[22]`, which is virtual address bit 31.
- R10: Reset and invalidation set every tag and data bit to one. The tag is one bit wider than the VPN, so an invalid entry never matches, not even VPN 0x7FFFFF.
- R11: A fill and a single-entry invalidate in the same cycle both take effect when they target different entries. When they target the same entry, the invalidate wins.
- R12: A response appears one cycle after acceptance. `lk_ready` = !`rs_valid` || `rs_ready`. A stalled response holds its value, and a miss reports `rs_paddr` = 0.
- R13: The debug port reads the entry at `dbg_idx` combinationally and writes it with `dbg_we`. Data bit layout: [29:9] frame, [8:5] read bits by mode, [4:1] write bits by mode, [0] modified flag. Tag layout: [23] invalid marker, [22:0] VPN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request ready |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_mode | input | 2 | Privilege mode of the lookup |
| lk_write | input | 1 | Lookup is a write |
| lk_probe | input | 1 | Probe lookup (modified flag ignored) |
| rs_valid | output | 1 | Response valid |
| rs_ready | input | 1 | Response ready |
| rs_hit | output | 1 | 1 = hit, 0 = miss (fill needed) |
| rs_paddr | output | 30 | Physical address on a hit, zero on a miss |
| fill_en | input | 1 | Write one entry from the fill port |
| fill_vpn | input | 23 | VPN of the entry to fill |
| fill_pfn | input | 21 | Frame number to store |
| fill_rd | input | 4 | Read-enable bits, indexed by mode |
| fill_wr | input | 4 | Write-enable bits, indexed by mode |
| fill_mod | input | 1 | Modified flag to store |
| inv_op | input | 2 | 0 none, 1 process buffer, 2 both buffers, 3 single entry |
| inv_vpn | input | 23 | VPN selecting the entry for operation 3 |
| dbg_sys | input | 1 | Debug port buffer select (1 = system) |
| dbg_idx | input | 7 | Debug entry index |
| dbg_we | input | 1 | Debug write enable |
| dbg_wtag | input | 24 | Debug tag to write |
| dbg_wdata | input | 30 | Debug data to write |
| dbg_rtag | output | 24 | Tag of the selected entry |
| dbg_rdata | output | 30 | Data of the selected entry |

## Verification
The bench targets five corner cases. It looks up a second VPN that aliases to an index already filled; a design that compares only the index would return a false hit. It looks up the all-ones VPN right after reset; a tag no wider than the VPN would match the invalid pattern. It issues write lookups against an entry whose modified flag is clear, with the probe flag both clear and set; a design that mixes up the two cases either skips the modified check or faults probes. It drives a fill and a single-entry invalidate in the same cycle, once to different entries and once to the same entry, which exposes a wrong priority or a lost update. It stalls the response channel and watches for a response that changes or drops while `rs_ready` is low.

// File: rtl/tlbs_pkg.sv
package tlbs_pkg;
  localparam int VA_W      = 32;
  localparam int PAGE_BITS = 9;
  localparam int IDX_BITS  = 7;
  localparam int PA_W      = 30;
  localparam int MODES     = 4;
  localparam int MODE_W    = $clog2(MODES);
  localparam int VPN_W     = VA_W - PAGE_BITS;
  localparam int TAG_W     = VPN_W + 1;
  localparam int PFN_W     = PA_W - PAGE_BITS;
  localparam int ENT_W     = PFN_W + 2 * MODES + 1;
  localparam int NBANKS    = 2;

  typedef struct packed {
    logic [PFN_W-1:0] pfn;
    logic [MODES-1:0] rd;
    logic [MODES-1:0] wr;
    logic             mod;
  } tlb_ent_t;

  typedef enum logic [1:0] {
    INV_NONE = 2'd0,
    INV_PROC = 2'd1,
    INV_ALL  = 2'd2,
    INV_ONE  = 2'd3
  } inv_op_e;
endpackage

// File: rtl/tlb_bank.sv
module tlb_bank
  import tlbs_pkg::*;
#(
  parameter int IW = IDX_BITS,
  localparam int DEPTH = 1 << IW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             inv_en,
  input  logic [IW-1:0]    inv_idx,
  input  logic             fill_en,
  input  logic [IW-1:0]    fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  input  tlb_ent_t         fill_ent,
  input  logic             dbg_we,
  input  logic [IW-1:0]    dbg_idx,
  input  logic [TAG_W-1:0] dbg_tag,
  input  tlb_ent_t         dbg_ent,
  input  logic [IW-1:0]    rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output tlb_ent_t         rd_ent,
  output logic [TAG_W-1:0] dbg_rtag,
  output tlb_ent_t         dbg_rent
);
  logic [TAG_W-1:0] tag_q [DEPTH];
  tlb_ent_t         ent_q [DEPTH];

  // Priority per entry: invalidate > fill > debug write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        tag_q[i] <= '1;
        ent_q[i] <= '1;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (flush || (inv_en && inv_idx == IW'(i))) begin
          tag_q[i] <= '1;
          ent_q[i] <= '1;
        end else if (fill_en && fill_idx == IW'(i)) begin
          tag_q[i] <= fill_tag;
          ent_q[i] <= fill_ent;
        end else if (dbg_we && dbg_idx == IW'(i)) begin
          tag_q[i] <= dbg_tag;
          ent_q[i] <= dbg_ent;
        end
      end
    end
  end

  assign rd_tag   = tag_q[rd_idx];
  assign rd_ent   = ent_q[rd_idx];
  assign dbg_rtag = tag_q[dbg_idx];
  assign dbg_rent = ent_q[dbg_idx];

  // R9: a single invalidate leaves its entry all ones
  a_r9_single_inv: assert property (@(posedge clk) disable iff (!rst_n)
    inv_en |=> (&tag_q[$past(inv_idx)]) && (&ent_q[$past(inv_idx)]));

  // R11: a fill lands unless the same entry is invalidated
  a_r11_fill_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !flush && !(inv_en && inv_idx == fill_idx))
      |=> tag_q[$past(fill_idx)] == $past(fill_tag));

  // R8: a flush clears the first and last entries
  a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (&tag_q[0]) && (&tag_q[DEPTH-1]));
endmodule

// File: rtl/tlb_match.sv
module tlb_match
  import tlbs_pkg::*;
(
  input  logic [TAG_W-1:0]  tag,
  input  tlb_ent_t          ent,
  input  logic [VPN_W-1:0]  vpn,
  input  logic [MODE_W-1:0] mode,
  input  logic              write,
  input  logic              probe,
  output logic              hit
);
  logic tag_ok, perm_ok, mod_ok;

  always_comb begin
    tag_ok  = (tag == {1'b0, vpn});
    perm_ok = write ? ent.wr[mode] : ent.rd[mode];
    mod_ok  = !write || probe || ent.mod;
    hit     = tag_ok && perm_ok && mod_ok;
  end
endmodule

// File: rtl/tlb_split.sv
module tlb_split
  import tlbs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic [MODE_W-1:0] lk_mode,
  input  logic              lk_write,
  input  logic              lk_probe,
  output logic              rs_valid,
  input  logic              rs_ready,
  output logic              rs_hit,
  output logic [PA_W-1:0]   rs_paddr,
  input  logic              fill_en,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic [MODES-1:0]  fill_rd,
  input  logic [MODES-1:0]  fill_wr,
  input  logic              fill_mod,
  input  logic [1:0]        inv_op,
  input  logic [VPN_W-1:0]  inv_vpn,
  input  logic              dbg_sys,
  input  logic [IDX_BITS-1:0] dbg_idx,
  input  logic              dbg_we,
  input  logic [TAG_W-1:0]  dbg_wtag,
  input  logic [ENT_W-1:0]  dbg_wdata,
  output logic [TAG_W-1:0]  dbg_rtag,
  output logic [ENT_W-1:0]  dbg_rdata
);
  inv_op_e          op;
  logic [VPN_W-1:0] lk_vpn;
  logic [IDX_BITS-1:0] lk_idx;
  logic             lk_sel;
  tlb_ent_t         fill_word;

  logic [TAG_W-1:0] b_tag  [NBANKS];
  tlb_ent_t         b_ent  [NBANKS];
  logic [TAG_W-1:0] b_dtag [NBANKS];
  tlb_ent_t         b_dent [NBANKS];
  logic             b_hit  [NBANKS];

  assign op        = inv_op_e'(inv_op);
  assign lk_vpn    = lk_vaddr[VA_W-1:PAGE_BITS];
  assign lk_idx    = lk_vpn[IDX_BITS-1:0];
  assign lk_sel    = lk_vaddr[VA_W-1];
  assign fill_word = '{pfn: fill_pfn, rd: fill_rd, wr: fill_wr, mod: fill_mod};

  // Bank 0 serves the process half, bank 1 the system half.
  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    logic flush_b, inv_b, fill_b, dbg_b;
    assign flush_b = (op == INV_ALL) || (b == 0 && op == INV_PROC);
    assign inv_b   = (op == INV_ONE) && (inv_vpn[VPN_W-1] == 1'(b));
    assign fill_b  = fill_en && (fill_vpn[VPN_W-1] == 1'(b));
    assign dbg_b   = dbg_we && (dbg_sys == 1'(b));

    tlb_bank #(.IW(IDX_BITS)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush_b),
      .inv_en   (inv_b),
      .inv_idx  (inv_vpn[IDX_BITS-1:0]),
      .fill_en  (fill_b),
      .fill_idx (fill_vpn[IDX_BITS-1:0]),
      .fill_tag ({1'b0, fill_vpn}),
      .fill_ent (fill_word),
      .dbg_we   (dbg_b),
      .dbg_idx  (dbg_idx),
      .dbg_tag  (dbg_wtag),
      .dbg_ent  (tlb_ent_t'(dbg_wdata)),
      .rd_idx   (lk_idx),
      .rd_tag   (b_tag[b]),
      .rd_ent   (b_ent[b]),
      .dbg_rtag (b_dtag[b]),
      .dbg_rent (b_dent[b])
    );

    tlb_match u_match (
      .tag   (b_tag[b]),
      .ent   (b_ent[b]),
      .vpn   (lk_vpn),
      .mode  (lk_mode),
      .write (lk_write),
      .probe (lk_probe),
      .hit   (b_hit[b])
    );
  end

  assign dbg_rtag  = b_dtag[dbg_sys];
  assign dbg_rdata = b_dent[dbg_sys];

  logic accept;
  assign lk_ready = !rs_valid || rs_ready;
  assign accept   = lk_valid && lk_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_valid <= 1'b0;
      rs_hit   <= 1'b0;
      rs_paddr <= '0;
    end else if (accept) begin
      rs_valid <= 1'b1;
      rs_hit   <= b_hit[lk_sel];
      rs_paddr <= b_hit[lk_sel] ? {b_ent[lk_sel].pfn, lk_vaddr[PAGE_BITS-1:0]} : '0;
    end else if (rs_ready) begin
      rs_valid <= 1'b0;
    end
  end

  // R12: a stalled response holds
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_ready) |=> rs_valid && $stable(rs_hit) && $stable(rs_paddr));

  // R12: an accepted request yields a response next cycle
  a_r12_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> rs_valid);

  // R12: a miss carries a zero address
  a_r12_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_hit) |-> rs_paddr == '0);

  // R2: a hit keeps the page offset of its request
  a_r2_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> !rs_hit || rs_paddr[PAGE_BITS-1:0] == $past(lk_vaddr[PAGE_BITS-1:0]));
endmodule

// File: tb/tlb_split_tb_top.sv
`timescale 1ns/1ps
module tlb_split_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic        lk_ready;
  logic [31:0] lk_vaddr = '0;
  logic [1:0]  lk_mode = '0;
  logic        lk_write = 1'b0;
  logic        lk_probe = 1'b0;
  logic        rs_valid;
  logic        rs_ready = 1'b1;
  logic        rs_hit;
  logic [29:0] rs_paddr;
  logic        fill_en = 1'b0;
  logic [22:0] fill_vpn = '0;
  logic [20:0] fill_pfn = '0;
  logic [3:0]  fill_rd = '0;
  logic [3:0]  fill_wr = '0;
  logic        fill_mod = 1'b0;
  logic [1:0]  inv_op = '0;
  logic [22:0] inv_vpn = '0;
  logic        dbg_sys = 1'b0;
  logic [6:0]  dbg_idx = '0;
  logic        dbg_we = 1'b0;
  logic [23:0] dbg_wtag = '0;
  logic [29:0] dbg_wdata = '0;
  logic [23:0] dbg_rtag;
  logic [29:0] dbg_rdata;

  always #4 clk = ~clk;

  tlb_split dut_i (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_vaddr(lk_vaddr),
    .lk_mode(lk_mode), .lk_write(lk_write), .lk_probe(lk_probe),
    .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_hit(rs_hit), .rs_paddr(rs_paddr),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .fill_rd(fill_rd), .fill_wr(fill_wr), .fill_mod(fill_mod),
    .inv_op(inv_op), .inv_vpn(inv_vpn),
    .dbg_sys(dbg_sys), .dbg_idx(dbg_idx), .dbg_we(dbg_we),
    .dbg_wtag(dbg_wtag), .dbg_wdata(dbg_wdata),
    .dbg_rtag(dbg_rtag), .dbg_rdata(dbg_rdata)
  );

  int checks = 0;
  int failures = 0;

  typedef struct {
    logic        hit;
    logic [29:0] pa;
    string       tg;
  } exp_t;
  exp_t sb_q[$];

  task automatic chk(bit ok, string tg, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tg, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Monitor: take each delivered response and compare against the queue
  initial begin
    forever begin
      @(negedge clk);
      if (rs_valid && rs_ready) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R12 unexpected response", {1'b0, rs_hit, rs_paddr}, 32'h0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk({rs_hit, rs_paddr} == {e.hit, e.pa}, e.tg,
              {1'b0, rs_hit, rs_paddr}, {1'b0, e.hit, e.pa});
        end
      end
    end
  end

  // Driver: push the expectation, then hold the request until accepted
  task automatic look(logic [31:0] va, logic [1:0] md, bit w, bit pr,
                      bit eh, logic [29:0] epa, string tg);
    exp_t e;
    bit   got;
    e.hit = eh;
    e.pa  = eh ? epa : 30'h0;
    e.tg  = tg;
    sb_q.push_back(e);
    lk_vaddr = va; lk_mode = md; lk_write = w; lk_probe = pr; lk_valid = 1'b1;
    do begin
      @(negedge clk);
      got = lk_ready;
      @(posedge clk);
      #2;
    end while (!got);
    lk_valid = 1'b0;
  endtask

  task automatic drain();
    repeat (3) @(posedge clk);
    #2;
    chk(sb_q.size() == 0, "R12 responses outstanding", sb_q.size(), 0);
  endtask

  task automatic maint(bit fe, logic [31:0] fva, logic [20:0] pfn, logic [3:0] rd,
                       logic [3:0] wr, bit md, logic [1:0] op, logic [31:0] iva);
    fill_en = fe; fill_vpn = fva[31:9]; fill_pfn = pfn;
    fill_rd = rd; fill_wr = wr; fill_mod = md;
    inv_op = op; inv_vpn = iva[31:9];
    @(posedge clk);
    #2;
    fill_en = 1'b0; inv_op = 2'd0;
  endtask

  task automatic dread(bit sys, logic [6:0] idx, logic [23:0] etag,
                       logic [29:0] edata, string tg);
    dbg_sys = sys; dbg_idx = idx;
    #1;
    chk(dbg_rtag == etag, tg, {8'h0, dbg_rtag}, {8'h0, etag});
    chk(dbg_rdata == edata, tg, {2'b0, dbg_rdata}, {2'b0, edata});
  endtask

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    rst_n = 1'b1;
    @(posedge clk);
    #2;

    // R12 / R10 reset state
    chk(rs_valid == 1'b0, "R12 reset rs_valid", rs_valid, 0);
    chk(lk_ready == 1'b1, "R12 reset lk_ready", lk_ready, 1);
    dread(1'b1, 7'd5, 24'hFFFFFF, 30'h3FFFFFFF, "R10 reset entry all ones");
    look(32'hFFFF_FE00, 2'd0, 1'b0, 1'b0, 1'b0, 30'h0, "R10 all-ones VPN misses");

    // Process entry: kernel-only write, read for all modes, modified set
    maint(1'b1, 32'h0000_0A00, 21'h1234, 4'hF, 4'h1, 1'b1, 2'd0, 32'h0);
    look(32'h0000_0A37, 2'd0, 1'b0, 1'b0, 1'b1, 30'h246837, "R2 kernel read hit");
    look(32'h0000_0A37, 2'd3, 1'b0, 1'b0, 1'b1, 30'h246837, "R4 user read hit");
    look(32'h0000_0A37, 2'd3, 1'b1, 1'b0, 1'b0, 30'h0, "R4 user write denied");
    look(32'h0000_0A37, 2'd0, 1'b1, 1'b0, 1'b1, 30'h246837, "R4 kernel write hit");
    look(32'h8000_0A10, 2'd0, 1'b0, 1'b0, 1'b0, 30'h0, "R1 system half empty");
    look(32'h0001_0A00, 2'd0, 1'b0, 1'b0, 1'b0, 30'h0, "R3 aliased VPN misses");

    // System entry: kernel only, modified clear
    maint(1'b1, 32'h8000_0A00, 21'h00ABC, 4'h1, 4'h1, 1'b0, 2'd0, 32'h0);
    look(32'h8000_0A10, 2'd0, 1'b0, 1'b0, 1'b1, 30'h157810, "R1 system read hit");
    look(32'h8000_0A10, 2'd1, 1'b0, 1'b0, 1'b0, 30'h0, "R4 exec read denied");
    look(32'h8000_0A10, 2'd0, 1'b1, 1'b0, 1'b0, 30'h0, "R5 write needs modified");
    look(32'h8000_0A10, 2'd0, 1'b1, 1'b1, 1'b1, 30'h157810, "R6 probe ignores modified");
    drain();

    // Debug port
    dread(1'b0, 7'd5, 24'h000005, 30'h2469E3, "R13 debug read layout");
    dbg_sys = 1'b0; dbg_idx = 7'd9; dbg_wtag = 24'h000009; dbg_wdata = 30'hFFF; dbg_we = 1'b1;
    @(posedge clk);
    #2;
    dbg_we = 1'b0;
    look(32'h0000_1244, 2'd2, 1'b1, 1'b0, 1'b1, 30'hE44, "R13 debug-written entry hits");
    drain();

    // Process-only flush
    maint(1'b0, 32'h0, 21'h0, 4'h0, 4'h0, 1'b0, 2'd1, 32'h0);
    look(32'h0000_0A37, 2'd0, 1'b0, 1'b0, 1'b0, 30'h0, "R7 process entry flushed");
    look(32'h8000_0A10, 2'd0, 1'b0, 1'b0, 1'b1, 30'h157810, "R7 system entry kept");
    drain();
    dread(1'b0, 7'd5, 24'hFFFFFF, 30'h3FFFFFFF, "R10 flushed entry all ones");

    // Single-entry invalidate of the system half
    maint(1'b1, 32'h0000_0A00, 21'h1234, 4'hF, 4'h1, 1'b1, 2'd0, 32'h0);
    maint(1'b0, 32'h0, 21'h0, 4'h0, 4'h0, 1'b0, 2'd3, 32'h8000_0A00);
    look(32'h8000_0A10, 2'd0, 1'b0, 1'b0, 1'b0, 30'h0, "R9 system entry invalidated");
    look(32'h0000_0A37, 2'd0, 1'b0, 1'b0, 1'b1, 30'h246837, "R9 process twin kept");
    drain();

    // Fill and invalidate in the same cycle
    maint(1'b1, 32'h0000_0C00, 21'h11, 4'hF, 4'hF, 1'b1, 2'd3, 32'h0000_0A00);
    look(32'h0000_0C00, 2'd0, 1'b0, 1'b0, 1'b1, 30'h2200, "R11 fill beside invalidate");
    look(32'h0000_0A37, 2'd0, 1'b0, 1'b0, 1'b0, 30'h0, "R11 invalidate beside fill");
    maint(1'b1, 32'h0000_0E00, 21'h22, 4'hF, 4'hF, 1'b1, 2'd3, 32'h0000_0E00);
    look(32'h0000_0E00, 2'd0, 1'b0, 1'b0, 1'b0, 30'h0, "R11 same entry invalidate wins");
    drain();

    // Flush both halves
    maint(1'b1, 32'h8000_0A00, 21'h00ABC, 4'h1, 4'h1, 1'b0, 2'd0, 32'h0);
    maint(1'b0, 32'h0, 21'h0, 4'h0, 4'h0, 1'b0, 2'd2, 32'h0);
    look(32'h8000_0A10, 2'd0, 1'b0, 1'b0, 1'b0, 30'h0, "R8 system flushed");
    look(32'h0000_0C00, 2'd0, 1'b0, 1'b0, 1'b0, 30'h0, "R8 process flushed");
    drain();

    // Back-pressure on the response channel
    maint(1'b1, 32'h0000_0C00, 21'h11, 4'hF, 4'hF, 1'b1, 2'd0, 32'h0);
    rs_ready = 1'b0;
    look(32'h0000_0C05, 2'd1, 1'b0, 1'b0, 1'b1, 30'h2205, "R12 stalled response value");
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(rs_valid && rs_hit && rs_paddr == 30'h2205, "R12 response held",
          {1'b0, rs_valid, rs_paddr}, {2'b01, 30'h2205});
      chk(lk_ready == 1'b0, "R12 lk_ready low while stalled", lk_ready, 0);
    end
    @(posedge clk);
    #2;
    rs_ready = 1'b1;
    drain();

    finish_up();
  end
endmodule